// File: doc/BRIEF.md
# Physical Address Window Router

This block sits between a cache and two downstream master ports. Each physical address arrives with a valid strobe and is sent to exactly one port. Addresses inside a programmable window go to the memory-controller port (M1). All other addresses go to the interconnect port (M0). The address is passed on unchanged beside the one-hot select.

The window has a 1 MiB granularity, so only the top twelve address bits are compared. Its lower bound is inclusive and its upper bound is exclusive. Two configuration words describe the window: a lower-bound word that also carries an enable flag, and an upper-bound word. Both are reached through a plain 32-bit read/write register port.

The window is active from reset with non-zero bounds. A write that puts any bit below the 1 MiB boundary into a bound raises a one-cycle error flag. A separate level output shows whether the programmed window is non-empty.

Top module: `phys_addr_steer`

## Requirements
- R1: After reset, reading offset 0xC00 returns 0x0010_0001 and reading offset 0xC04 returns 0xC000_0000.
- R2: Offset 0xC00 stores bits [31:20] as the lower bound and bit 0 as the enable flag; its bits [19:1] always read as zero. Offset 0xC04 stores bits [31:20] as the upper bound; its bits [19:0] always read as zero.
- R3: When the filter is enabled and lower <= addr[31:20] < upper, a valid request drives `port_sel` = 2'b10 (bit 1 = M1) in the same cycle.
- R4: An enabled request whose addr[31:20] is below the lower bound, or at or above the upper bound, drives `port_sel` = 2'b01 (bit 0 = M0). Both bounds are checked at their exact edges.
- R5: While the enable flag (bit 0 at 0xC00) is 0, every valid request drives `port_sel` = 2'b01.
- R6: `cfg_window_ok` is 1 exactly when lower < upper. When the lower bound is at or above the upper bound, every valid request goes to M0.
- R7: With `req_valid` low, `port_sel` is 2'b00. `out_addr` always equals `req_addr`.
- R8: A bound write with any of bits [19:1] set (offset 0xC00) or any of bits [19:0] set (offset 0xC04) raises `cfg_range_err` for the one cycle after the write edge. The upper bits are still stored. A clean write leaves `cfg_range_err` low.
- R9: A register write takes effect at the clock edge that samples it. A request in the same cycle as the write is routed with the old settings.
- R10: A read of any other offset returns zero, and a write to any other offset changes no register and raises no error.
- R11: Address bits [19:0] have no effect on the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_ofs | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational, zero when not reading) |
| cfg_range_err | output | 1 | One-cycle flag: previous write set bits below the 1 MiB boundary |
| cfg_window_ok | output | 1 | Lower bound is strictly below the upper bound |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Physical address of the request |
| port_sel | output | 2 | One-hot select: bit 0 = M0 interconnect, bit 1 = M1 memory controller |
| out_addr | output | 32 | Request address passed through |

## Verification
The hardest case to reach is a request issued in the very cycle a bound write is sampled. Only there does the difference between old and new settings show at the ports. The stimulus drives a lower-bound write together with an address that lies between the old and the new bound. It expects M1 in that cycle and then M0 for the same address one cycle later. Window edges are probed at the exact bound addresses and one step below them. Noisy low address bits are mixed in to show that they are ignored.

// File: rtl/pas_pkg.sv
package pas_pkg;
  parameter int PAS_ADDR_W   = 32;
  parameter int PAS_GRAN_LSB = 20;
  parameter int PAS_FIELD_W  = PAS_ADDR_W - PAS_GRAN_LSB;

  typedef enum logic [1:0] {
    SEL_NONE = 2'b00,
    SEL_M0   = 2'b01,
    SEL_M1   = 2'b10
  } port_sel_e;

  // Half-open window test on the coarse address field.
  function automatic logic in_window(input logic [PAS_FIELD_W-1:0] a,
                                     input logic [PAS_FIELD_W-1:0] lo,
                                     input logic [PAS_FIELD_W-1:0] hi);
    return (a >= lo) && (a < hi);
  endfunction

  // Window is non-empty only when the lower bound is below the upper bound.
  function automatic logic window_nonempty(input logic [PAS_FIELD_W-1:0] lo,
                                           input logic [PAS_FIELD_W-1:0] hi);
    return lo < hi;
  endfunction
endpackage

// File: rtl/pas_cfg_regs.sv
module pas_cfg_regs
  import pas_pkg::*;
#(
  parameter int ADDR_W   = PAS_ADDR_W,
  parameter int GRAN_LSB = PAS_GRAN_LSB,
  parameter int REG_AW   = 12,
  parameter logic [REG_AW-1:0] LO_OFS = 12'hC00,
  parameter logic [REG_AW-1:0] HI_OFS = 12'hC04,
  parameter logic [ADDR_W-1:0] LO_RST = 32'h0010_0000,
  parameter logic              EN_RST = 1'b1,
  parameter logic [ADDR_W-1:0] HI_RST = 32'hC000_0000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [REG_AW-1:0]         ofs,
  input  logic [ADDR_W-1:0]         wdata,
  output logic [ADDR_W-1:0]         rdata,
  output logic [ADDR_W-GRAN_LSB-1:0] lo_field,
  output logic [ADDR_W-GRAN_LSB-1:0] hi_field,
  output logic                      enable,
  output logic                      range_err
);
  localparam int FIELD_W = ADDR_W - GRAN_LSB;

  logic [FIELD_W-1:0] lo_q, hi_q;
  logic               en_q, err_q;

  // Named decode events, used by the assertions below.
  logic lo_hit, hi_hit, lo_stray, hi_stray;
  assign lo_hit   = wr_en && (ofs == LO_OFS);
  assign hi_hit   = wr_en && (ofs == HI_OFS);
  assign lo_stray = |wdata[GRAN_LSB-1:1];
  assign hi_stray = |wdata[GRAN_LSB-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= LO_RST[ADDR_W-1:GRAN_LSB];
      en_q  <= EN_RST;
      hi_q  <= HI_RST[ADDR_W-1:GRAN_LSB];
      err_q <= 1'b0;
    end else begin
      if (lo_hit) begin
        lo_q <= wdata[ADDR_W-1:GRAN_LSB];
        en_q <= wdata[0];
      end
      if (hi_hit) hi_q <= wdata[ADDR_W-1:GRAN_LSB];
      err_q <= (lo_hit && lo_stray) || (hi_hit && hi_stray);
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (ofs == LO_OFS)      rdata = {lo_q, {(GRAN_LSB-1){1'b0}}, en_q};
      else if (ofs == HI_OFS) rdata = {hi_q, {GRAN_LSB{1'b0}}};
    end
  end

  assign lo_field  = lo_q;
  assign hi_field  = hi_q;
  assign enable    = en_q;
  assign range_err = err_q;

  // R8: a stray-bit bound write raises the flag on the next cycle
  a_r8_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
    ((lo_hit && lo_stray) || (hi_hit && hi_stray)) |=> range_err);
  // R8: no write, no flag
  a_r8_flag_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !range_err);
  // R9 / R10: bounds only change when their own offset is written
  a_r9_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_hit |=> ($stable(lo_field) && $stable(enable)));
  a_r9_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_hit |=> $stable(hi_field));
endmodule

// File: rtl/pas_window_route.sv
module pas_window_route
  import pas_pkg::*;
#(
  parameter int ADDR_W   = PAS_ADDR_W,
  parameter int GRAN_LSB = PAS_GRAN_LSB
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic [ADDR_W-GRAN_LSB-1:0] lo_field,
  input  logic [ADDR_W-GRAN_LSB-1:0] hi_field,
  input  logic                       enable,
  output logic [1:0]                 port_sel,
  output logic                       win_open
);
  localparam int FIELD_W = ADDR_W - GRAN_LSB;

  logic [FIELD_W-1:0] addr_field;
  logic               hit;

  assign addr_field = req_addr[ADDR_W-1:GRAN_LSB];
  assign win_open   = window_nonempty(lo_field, hi_field);
  assign hit        = enable && in_window(addr_field, lo_field, hi_field);

  always_comb begin
    if (!req_valid) port_sel = SEL_NONE;
    else if (hit)   port_sel = SEL_M1;
    else            port_sel = SEL_M0;
  end

  // R7: exactly one port per valid request, none otherwise
  a_r7_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(port_sel) == 1));
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (port_sel == 2'b00));
  // R5: a disabled filter never selects M1
  a_r5_off_m0: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !port_sel[1]);
  // R6: an empty window never selects M1
  a_r6_empty_m0: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> !port_sel[1]);
endmodule

// File: rtl/phys_addr_steer.sv
module phys_addr_steer
  import pas_pkg::*;
#(
  parameter int ADDR_W   = PAS_ADDR_W,
  parameter int GRAN_LSB = PAS_GRAN_LSB,
  parameter int REG_AW   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic              cfg_rd_en,
  input  logic [REG_AW-1:0] cfg_ofs,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic [ADDR_W-1:0] cfg_rdata,
  output logic              cfg_range_err,
  output logic              cfg_window_ok,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [1:0]        port_sel,
  output logic [ADDR_W-1:0] out_addr
);
  localparam int FIELD_W = ADDR_W - GRAN_LSB;

  logic [FIELD_W-1:0] lo_field, hi_field;
  logic               enable;

  pas_cfg_regs #(
    .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB), .REG_AW(REG_AW)
  ) regs_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .ofs(cfg_ofs),
    .wdata(cfg_wdata), .rdata(cfg_rdata),
    .lo_field(lo_field), .hi_field(hi_field),
    .enable(enable), .range_err(cfg_range_err)
  );

  pas_window_route #(
    .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
  ) route_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .lo_field(lo_field), .hi_field(hi_field), .enable(enable),
    .port_sel(port_sel), .win_open(cfg_window_ok)
  );

  assign out_addr = req_addr;
endmodule

// File: tb/phys_addr_steer_tb_top.sv
`timescale 1ns/1ps
module phys_addr_steer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
  logic [11:0] cfg_ofs = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_range_err, cfg_window_ok;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  port_sel;
  logic [31:0] out_addr;

  always #2.5 clk = ~clk;

  phys_addr_steer dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_ofs(cfg_ofs),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_range_err(cfg_range_err), .cfg_window_ok(cfg_window_ok),
    .req_valid(req_valid), .req_addr(req_addr),
    .port_sel(port_sel), .out_addr(out_addr)
  );

  int checks = 0, errors = 0;
  bit reported = 0;

  // Reference copy of the programmed registers (full-width images).
  logic [31:0] m_lo = 32'h0010_0000, m_hi = 32'hC000_0000;
  logic        m_en = 1'b1;

  logic [1:0]  q_sel[$];
  logic [31:0] q_addr[$];
  int          q_req[$];

  task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  function automatic logic [1:0] expect_sel(input logic v, input logic [31:0] a);
    if (!v) return 2'b00;
    if (m_en && a >= m_lo && a < m_hi) return 2'b10;
    return 2'b01;
  endfunction

  // Driver: one cycle of stimulus; expected routing uses pre-write settings.
  task automatic drive(input logic wr, input logic [11:0] ofs, input logic [31:0] wd,
                       input logic rv, input logic [31:0] ra, input int req);
    @(posedge clk); #1;
    cfg_wr_en = wr; cfg_ofs = ofs; cfg_wdata = wd;
    req_valid = rv; req_addr = ra;
    q_sel.push_back(expect_sel(rv, ra));
    q_addr.push_back(ra);
    q_req.push_back(req);
    if (wr && ofs == 12'hC00) begin m_lo = wd & 32'hFFF0_0000; m_en = wd[0]; end
    if (wr && ofs == 12'hC04) m_hi = wd & 32'hFFF0_0000;
  endtask

  // Release the bus after a write and check the error flag it produced.
  task automatic settle(input logic exp_err, input int req);
    @(posedge clk); #1;
    cfg_wr_en = 1'b0; req_valid = 1'b0;
    chk(req, {31'b0, cfg_range_err}, {31'b0, exp_err}, "range error flag");
  endtask

  task automatic wr_reg(input logic [11:0] ofs, input logic [31:0] wd, input int req);
    logic e;
    e = (ofs == 12'hC00) ? |(wd & 32'h000F_FFFE) :
        (ofs == 12'hC04) ? |(wd & 32'h000F_FFFF) : 1'b0;
    drive(1'b1, ofs, wd, 1'b0, 32'h0, req);
    settle(e, req);
  endtask

  task automatic rd_reg(input logic [11:0] ofs, input logic [31:0] exp, input int req);
    @(posedge clk); #1;
    cfg_rd_en = 1'b1; cfg_ofs = ofs;
    #1;
    chk(req, cfg_rdata, exp, "register read");
    cfg_rd_en = 1'b0;
  endtask

  task automatic route(input logic [31:0] a, input int req);
    drive(1'b0, 12'h000, 32'h0, 1'b1, a, req);
  endtask

  // Monitor: compare scoreboard entries mid-cycle.
  always @(negedge clk) begin
    if (q_sel.size() > 0) begin
      logic [1:0] es; logic [31:0] ea; int r;
      es = q_sel.pop_front(); ea = q_addr.pop_front(); r = q_req.pop_front();
      chk(r, {30'b0, port_sel}, {30'b0, es}, "port select");
      chk(7, out_addr, ea, "address pass-through");
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R0 watchdog expired: actual=hung expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset values, R10: unmapped read
    rd_reg(12'hC00, 32'h0010_0001, 1);
    rd_reg(12'hC04, 32'hC000_0000, 1);
    rd_reg(12'hC08, 32'h0, 10);
    chk(6, {31'b0, cfg_window_ok}, 32'h1, "window ok after reset");
    // R3 / R4: default window edges
    route(32'h0000_0000, 4);
    route(32'h000F_FFFF, 4);
    route(32'h0010_0000, 3);
    route(32'hBFFF_FFFF, 3);
    route(32'hC000_0000, 4);
    route(32'hFFFF_FFFF, 4);
    route(32'h1234_5678, 3);
    drive(1'b0, 12'h0, 32'h0, 1'b0, 32'h5000_0000, 7); // R7: idle
    // R8 / R2: stray bits flagged, upper bits stored, low bits read zero
    wr_reg(12'hC00, 32'h2000_0F01, 8);
    rd_reg(12'hC00, 32'h2000_0001, 2);
    wr_reg(12'hC04, 32'h4000_0000, 8);
    rd_reg(12'hC04, 32'h4000_0000, 2);
    // R11: low address bits do not matter
    route(32'h1FFF_FFFF, 11);
    route(32'h2000_0000, 11);
    route(32'h200A_BCDE, 11);
    route(32'h3FFF_FFFF, 11);
    route(32'h4000_0000, 11);
    // R9: request in the write cycle sees the old lower bound
    drive(1'b1, 12'hC00, 32'h3000_0001, 1'b1, 32'h2800_0000, 9);
    route(32'h2800_0000, 9);
    route(32'h3000_0000, 9);
    // R5: disable
    wr_reg(12'hC00, 32'h3000_0000, 5);
    route(32'h3800_0000, 5);
    route(32'h3000_0000, 5);
    wr_reg(12'hC00, 32'h3000_0001, 5);
    route(32'h3800_0000, 5);
    // R6: empty windows
    wr_reg(12'hC04, 32'h3000_0000, 6);
    chk(6, {31'b0, cfg_window_ok}, 32'h0, "window ok equal bounds");
    route(32'h3000_0000, 6);
    wr_reg(12'hC04, 32'h1000_0000, 6);
    chk(6, {31'b0, cfg_window_ok}, 32'h0, "window ok inverted bounds");
    route(32'h2000_0000, 6);
    // R10: write to unmapped offset does nothing
    wr_reg(12'hC08, 32'hFFFF_FFFF, 10);
    rd_reg(12'hC00, 32'h3000_0001, 10);
    rd_reg(12'hC04, 32'h1000_0000, 10);
    // R8 / R2: upper bound with bit 0 set
    wr_reg(12'hC04, 32'h5000_0001, 8);
    rd_reg(12'hC04, 32'h5000_0000, 2);
    chk(6, {31'b0, cfg_window_ok}, 32'h1, "window ok restored");
    route(32'h4FFF_FFFF, 3);
    route(32'h5000_0000, 4);
    repeat (3) @(posedge clk);
    report();
    $finish;
  end
endmodule